// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. It decides when an embedded program or erase operation inside the flash has finished. After software or a sequencer has launched the operation, it pulses `start` with the address of the bank being worked on. The poller then issues a series of read requests to that address through a simple request/acknowledge port. That port faces a flash bus master, which generates the actual bus timing.

Each read returns a status word. Only two bits of it matter: bit 6 flips on every read while the flash is busy, and bit 5 reports that the internal operation has exceeded its limits. The poller compares bit 6 between consecutive reads. When bit 6 stops flipping, it reports success.

When bit 5 is set while bit 6 is still flipping, the poller rules out a race with a clean finish. It does this by taking two more reads and comparing them. If they also differ, it declares failure. Before reporting the failure, it writes the reset command code to the bank, because the flash accepts no other command until that code has been written. A read-count limit bounds the whole search.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `req_valid` are all low.
- R2: A `start` pulse seen while idle latches `bank_addr`, and every request of that run carries the latched address. A `start` seen while `busy` is high has no effect on the run in progress.
- R3: The first read of a run only sets the reference value of bit 6. If the next read returns the same bit 6, the run ends with success.
- R4: If bit 6 differs from the reference and bit 5 (mask 8'h20) is 0, another read follows, and it is compared against the latest bit 6.
- R5: If bit 6 differs and bit 5 is 1, exactly two more reads follow. If those two reads agree in bit 6, the run ends with success.
- R6: If the two confirmation reads of R5 differ in bit 6, the block issues one write with data `RST_CMD` (default 8'hF0) to the latched bank address. It raises `fail` only after that write is acknowledged.
- R7: A read that shows bit 6 toggling with bit 5 at 0 ends the run through the failure path of R6 when it is read number `MAX_READS` of the run.
- R8: A request keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` constant until the cycle in which `req_ack` is high. Read data is taken only in that cycle.
- R9: `done` and `fail` are single-cycle pulses, never high together. `busy` is low in the cycle in which either one is high.
- R10: Bits of the status word other than bits 5 and 6 have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| bank_addr | input | AW | Address of the bank under program/erase |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed or timed out |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Write data (reset command code) |
| req_ack | input | 1 | Request accepted; read data valid this cycle |
| rsp_rdata | input | DW | Read data |

## Verification
The hardest case to reach is the race path. Bit 5 rises on a read that still shows bit 6 toggling, and then the two confirmation reads agree, so the run must end in success rather than failure. A scripted responder in the bench returns a chosen sequence of bit-5/bit-6 pairs, one per acknowledged read, which places each branch exactly. It varies the acknowledge latency per vector and surrounds the two bits with changing filler data. A separate run keeps bit 6 toggling forever to reach the read-count limit.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_POLL  = 3'd2,
    ST_CONF1 = 3'd3,
    ST_CONF2 = 3'd4,
    ST_RSTWR = 3'd5
  } poll_state_t;

  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned LIMIT_BIT  = 5;

  // Bit 6 differs between two samples: the embedded operation is still running.
  function automatic logic has_toggled(input logic prev6, input logic now6);
    return prev6 ^ now6;
  endfunction

  // Width of a read counter able to hold values up to max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/tpoll_req.sv
module tpoll_req #(
  parameter int unsigned AW      = 22,
  parameter int unsigned DW      = 16,
  parameter logic [DW-1:0] RST_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_accept,
  input  logic [AW-1:0] bank_addr_i,
  input  logic          want_rd,
  input  logic          want_wr,
  input  logic          req_ack,
  input  logic [DW-1:0] rsp_rdata,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          smp_dq5,
  output logic          smp_dq6
);
  import tpoll_pkg::*;

  logic [AW-1:0] addr_q;
  logic          unused_rdata_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (start_accept) addr_q <= bank_addr_i;
  end

  assign req_valid = want_rd | want_wr;
  assign req_write = want_wr;
  assign req_addr  = addr_q;
  assign req_wdata = want_wr ? RST_CMD : '0;

  assign rd_fire = want_rd & req_ack;
  assign wr_fire = want_wr & req_ack;
  assign smp_dq5 = rsp_rdata[LIMIT_BIT];
  assign smp_dq6 = rsp_rdata[TOGGLE_BIT];
  assign unused_rdata_bits = ^rsp_rdata;

  // R8: a pending request holds its attributes until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_write)
                                 && $stable(req_addr) && $stable(req_wdata)));

  // R2: the address never moves while a request is outstanding
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !start_accept) |=> $stable(req_addr));

endmodule

// File: rtl/tpoll_rdcount.sv
module tpoll_rdcount #(
  parameter int unsigned MAX_READS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);
  import tpoll_pkg::*;

  localparam int unsigned CW = cnt_width(MAX_READS + 2);
  localparam logic [CW-1:0] LAST  = CW'(MAX_READS - 1);
  localparam logic [CW-1:0] CEIL  = CW'(MAX_READS + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (inc && cnt_q != CEIL)   cnt_q <= cnt_q + 1'b1;
  end

  // The acknowledged read is number MAX_READS of the run.
  assign limit_hit = (cnt_q >= LAST);

  // R7: the confirmation reads can run past the limit by at most two
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CEIL);

endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_fire,
  input  logic wr_fire,
  input  logic smp_dq5,
  input  logic smp_dq6,
  input  logic limit_hit,
  output logic start_accept,
  output logic want_rd,
  output logic want_wr,
  output logic busy,
  output logic done,
  output logic fail
);
  import tpoll_pkg::*;

  poll_state_t st_q, st_d;
  logic ref6_q, ref6_d;
  logic done_q, done_d, fail_q, fail_d;
  logic tog;

  assign tog          = has_toggled(ref6_q, smp_dq6);
  assign start_accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    ref6_d = ref6_q;
    done_d = 1'b0;
    fail_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_FIRST;
      ST_FIRST: if (rd_fire) begin
        ref6_d = smp_dq6;
        st_d   = ST_POLL;
      end
      ST_POLL: if (rd_fire) begin
        ref6_d = smp_dq6;
        if (!tog) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else if (smp_dq5) begin
          st_d = ST_CONF1;
        end else if (limit_hit) begin
          st_d = ST_RSTWR;
        end
      end
      ST_CONF1: if (rd_fire) begin
        ref6_d = smp_dq6;
        st_d   = ST_CONF2;
      end
      ST_CONF2: if (rd_fire) begin
        ref6_d = smp_dq6;
        if (tog) begin
          st_d = ST_RSTWR;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_RSTWR: if (wr_fire) begin
        st_d   = ST_IDLE;
        fail_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ref6_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ref6_q <= ref6_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign want_rd = (st_q == ST_FIRST) || (st_q == ST_POLL)
                || (st_q == ST_CONF1) || (st_q == ST_CONF2);
  assign want_wr = (st_q == ST_RSTWR);
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign fail    = fail_q;

  // R9: pulses are exclusive, single cycle, and coincide with idle
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  a_r9_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
  // R6: failure is reported only after the reset write was accepted
  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(wr_fire));
  // R3: success always follows an accepted read
  a_r3_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_fire));
  // R8: never read and write in the same request
  a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(want_rd && want_wr));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 16,
  parameter int unsigned MAX_READS = 1024,
  parameter logic [DW-1:0] RST_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] bank_addr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ack,
  input  logic [DW-1:0] rsp_rdata
);

  logic start_accept, want_rd, want_wr;
  logic rd_fire, wr_fire, smp_dq5, smp_dq6, limit_hit;

  tpoll_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_fire     (rd_fire),
    .wr_fire     (wr_fire),
    .smp_dq5     (smp_dq5),
    .smp_dq6     (smp_dq6),
    .limit_hit   (limit_hit),
    .start_accept(start_accept),
    .want_rd     (want_rd),
    .want_wr     (want_wr),
    .busy        (busy),
    .done        (done),
    .fail        (fail)
  );

  tpoll_req #(.AW(AW), .DW(DW), .RST_CMD(RST_CMD)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_accept(start_accept),
    .bank_addr_i (bank_addr),
    .want_rd     (want_rd),
    .want_wr     (want_wr),
    .req_ack     (req_ack),
    .rsp_rdata   (rsp_rdata),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_fire     (rd_fire),
    .wr_fire     (wr_fire),
    .smp_dq5     (smp_dq5),
    .smp_dq6     (smp_dq6)
  );

  tpoll_rdcount #(.MAX_READS(MAX_READS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_accept),
    .inc      (rd_fire),
    .limit_hit(limit_hit)
  );

  // R1: nothing is requested while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

endmodule

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int unsigned AW = 22;
  localparam int unsigned DW = 16;
  localparam int unsigned MAXR = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] bank_addr = '0;
  logic busy, done, fail, req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic req_ack = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .MAX_READS(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_addr(bank_addr),
    .busy(busy), .done(done), .fail(fail), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata));

  // {exp_fail, exp_reads[3:0], seq[15:0]}; read i: bit 2i = bit6, bit 2i+1 = bit5
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd2, 16'h0000},   // R3 stable at once
    {1'b0, 4'd3, 16'h0014},   // R4 one toggle then stable
    {1'b1, 4'd4, 16'h004C},   // R6 bit5, confirmation toggles
    {1'b0, 4'd4, 16'h000C},   // R5 bit5, confirmation stable at 0
    {1'b0, 4'd5, 16'h0011},   // R4 several toggles
    {1'b1, 4'd5, 16'h0131},   // R6 late bit5, still toggling
    {1'b0, 4'd4, 16'h005C},   // R5 race: confirmation stable at 1
    {1'b0, 4'd2, 16'h0002}    // R10 bit5 on first read is irrelevant
  };

  int n_tests = 0, n_fail = 0;
  int rd_idx = 0, wr_cnt = 0, addr_err = 0, wdata_err = 0;
  int lat = 0, wait_cnt = 0;
  logic [15:0] cur_seq = '0;
  logic toggle_forever = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  int cycles = 0;

  task automatic check(input string req, input logic cond, input int act, input int expv);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Scripted responder: acknowledges after lat idle cycles, data valid with ack
  always @(negedge clk) begin
    if (req_ack) begin
      req_ack <= 1'b0;
      wait_cnt <= lat;
    end else if (req_valid) begin
      if (wait_cnt > 0) wait_cnt <= wait_cnt - 1;
      else begin
        logic b6, b5;
        logic [DW-1:0] filler;
        req_ack <= 1'b1;
        if (req_addr != exp_addr) addr_err++;
        if (req_write) begin
          wr_cnt++;
          if (req_wdata != 16'h00F0) wdata_err++;
        end else begin
          if (toggle_forever || rd_idx >= 8) begin
            b6 = rd_idx[0]; b5 = 1'b0;
          end else begin
            b6 = cur_seq[2*rd_idx]; b5 = cur_seq[2*rd_idx+1];
          end
          filler = 16'(16'h9A3C ^ (rd_idx * 16'h2F1));
          rsp_rdata <= (filler & ~16'h0060) | {9'd0, b6, b5, 5'd0};
          rd_idx++;
        end
      end
    end
  end

  task automatic run_case(input string req, input logic [15:0] seq, input logic tf,
                          input logic [AW-1:0] addr, input int latency,
                          input int exp_reads, input logic exp_fail, input logic poke);
    int got_done = 0, got_fail = 0, both = 0;
    rd_idx = 0; wr_cnt = 0; addr_err = 0; wdata_err = 0;
    cur_seq = seq; toggle_forever = tf; lat = latency; wait_cnt = latency;
    exp_addr = addr;
    @(negedge clk); bank_addr = addr; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({req, " busy after start"}, busy === 1'b1, busy, 1);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin bank_addr = ~addr; start = 1'b1; end
      if (poke && i == 3) begin start = 1'b0; bank_addr = addr; end
      if (done && fail) both = 1;
      if (done || fail) begin
        got_done = int'(done); got_fail = int'(fail);
        check({req, " busy low at end"}, busy === 1'b0, busy, 0);
        break;
      end
    end
    check({req, " outcome fail"}, got_fail == int'(exp_fail) && got_done == int'(!exp_fail),
          got_fail, int'(exp_fail));
    check({req, " read count"}, rd_idx == exp_reads, rd_idx, exp_reads);
    check({req, " reset writes"}, wr_cnt == int'(exp_fail), wr_cnt, int'(exp_fail));
    check({req, " R2 address"}, addr_err == 0, addr_err, 0);
    check({req, " R6 write data"}, wdata_err == 0, wdata_err, 0);
    @(negedge clk);
    check({req, " R9 single pulse"}, !done && !fail && both == 0, int'(done | fail), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy/done/fail/req", !busy && !done && !fail && !req_valid,
          int'({busy, done, fail, req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", !busy && !req_valid, int'({busy, req_valid}), 0);
    for (int v = 0; v < NV; v++)
      run_case($sformatf("R3/R4/R5/R6/R8/R10 vec%0d", v), VEC[v][15:0], 1'b0,
               AW'(22'h1000 * (v + 1) + v), v % 3, int'(VEC[v][19:16]), VEC[v][20], 1'b0);
    // R2: start during a run is ignored
    run_case("R2 start while busy", 16'h0011, 1'b0, 22'h2ABCDE, 1, 5, 1'b0, 1'b1);
    // R7: endless toggling hits the read limit
    run_case("R7 timeout", 16'h0000, 1'b1, 22'h155555, 0, MAXR, 1'b1, 1'b0);
    // new run after a failure works normally
    run_case("R3 after failure", 16'h0000, 1'b0, 22'h000777, 2, 2, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    while (cycles < 50000) begin @(posedge clk); cycles++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule